// File: doc/BRIEF.md
# Cascadable Synchronous Loadable Binary Counter

This block is a chain of identical 4-bit synchronous binary counter slices. Each slice has an active-low synchronous clear and an active-low synchronous parallel load. It has two count enables, one for the count path and one for the carry path. It also has a carry output, qualified by the carry-path enable, so that slices can be chained. Every state bit of every slice updates on the same rising clock edge.

The top level joins two slices into an 8-bit counter. Clear and load go to both slices at once. A single master count enable drives both enables of the low slice. The carry of the low slice drives both enables of the high slice. The carry of the high slice is the chain's carry output, so further chains can be appended. If clear and load are held high and the enable is tied high, the chain runs freely and divides the clock by 256.

Top module: `counter_chain`

## Requirements
- R1: A clock edge with `clear_n` low makes `q` equal 0, whatever `load_n`, `cnt_en` and `data_in` are at that edge. Clear takes priority over load.
- R2: A clock edge with `clear_n` high and `load_n` low copies `data_in` into `q`, whether `cnt_en` is high or low.
- R3: A clock edge with `clear_n` and `load_n` high and `cnt_en` high increments `q` by one.
- R4: A clock edge with `clear_n` and `load_n` high and `cnt_en` low leaves `q` unchanged.
- R5: The carry of the low slice is 1 exactly when `q[3:0]` is 15 and `cnt_en` is 1. The high nibble advances only on such an edge, so counting from 0x0F gives 0x10.
- R6: `carry_out` is 1 exactly when `q` is 255 and `cnt_en` is 1. At 255 with `cnt_en` low, `carry_out` is 0.
- R7: Counting from 255 gives 0. In free-running operation, `carry_out` rises once every 256 clocks.
- R8: After a load, counting continues upward from the loaded value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Common clock; all state changes on its rising edge |
| clear_n | input | 1 | Synchronous clear, active low; also serves as reset |
| load_n | input | 1 | Synchronous parallel load, active low |
| cnt_en | input | 1 | Master count enable, feeds the low slice |
| data_in | input | 8 | Parallel load value, bit 0 least significant |
| q | output | 8 | Counter value, bit 0 least significant |
| carry_out | output | 1 | Carry of the high slice: all ones and enabled |

## Verification
Two pairs of functions can fall on the same edge: clear with load, and load with an active count enable. The bench asserts clear and load together, with the enable high and a nonzero data value. A correct result is zero, not the data. It also loads while the enable is high, and a correct result is the data, not the data plus one. A behavioural model applies the priority order, and every cycle is compared against it. The cycles around 0x0F, 0xFF and the enable-low hold at 0xFF show whether carry gating and chaining are right.

// File: rtl/cnt_pkg.sv
// Shared types for the counter chain.
// Assumes: nothing beyond IEEE 1800-2017.
package cnt_pkg;

    // Operation one slice performs on the next clock edge.
    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_COUNT = 2'd1,
        OP_LOAD  = 2'd2,
        OP_CLEAR = 2'd3
    } slice_op_e;

endpackage

// File: rtl/cnt_slice_ctrl.sv
// Control decode for one counter slice.
// Picks the edge operation by fixed priority: clear, then load, then count.
// Counting needs both enables. Otherwise the slice holds.
// Assumes: all inputs are synchronous to the slice clock.
module cnt_slice_ctrl
    import cnt_pkg::*;
(
    input  logic      clear_n,
    input  logic      load_n,
    input  logic      en_p,
    input  logic      en_t,
    output slice_op_e op
);

    // Priority decode of the control pins.
    always_comb begin
        if (!clear_n) begin
            op = OP_CLEAR;
        end else if (!load_n) begin
            op = OP_LOAD;
        end else if (en_p && en_t) begin
            op = OP_COUNT;
        end else begin
            op = OP_HOLD;
        end
    end

endmodule

// File: rtl/cnt_slice.sv
// One synchronous binary counter slice of parameterised width.
// State changes only on the rising clock edge. Clear acts as the synchronous
// active-low reset. The carry output is high when the slice is all ones and
// the carry-path enable is high, so slices can be chained.
// Assumes: clear_n is driven low for at least one edge before q is used.
module cnt_slice
    import cnt_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             clear_n,
    input  logic             load_n,
    input  logic             en_p,
    input  logic             en_t,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q,
    output logic             rco
);

    localparam logic [WIDTH-1:0] ONE = {{(WIDTH-1){1'b0}}, 1'b1};

    slice_op_e        op;
    logic [WIDTH-1:0] q_nxt;

    cnt_slice_ctrl u_ctrl (
        .clear_n (clear_n),
        .load_n  (load_n),
        .en_p    (en_p),
        .en_t    (en_t),
        .op      (op)
    );

    // Next-state selection for the chosen operation.
    always_comb begin
        unique case (op)
            OP_CLEAR: q_nxt = '0;
            OP_LOAD:  q_nxt = d;
            OP_COUNT: q_nxt = q + ONE;
            default:  q_nxt = q;
        endcase
    end

    // State register, all bits on one common edge.
    always_ff @(posedge clk) begin
        q <= q_nxt;
    end

    // Carry: terminal count, gated by the carry-path enable.
    always_comb begin
        rco = en_t && (&q);
    end

endmodule

// File: rtl/counter_chain.sv
// Chain of counter slices that forms a wider synchronous counter.
// Clear and load fan out to every slice. The master enable feeds both enables
// of slice 0. The carry of each slice feeds both enables of the next slice.
// The carry of the last slice is the chain carry output.
// Assumes: data_in is stable around the clock edge when load is used.
module counter_chain #(
    parameter int SLICE_W    = 4,
    parameter int NUM_SLICES = 2,
    localparam int TOTAL_W   = SLICE_W * NUM_SLICES
) (
    input  logic               clk,
    input  logic               clear_n,
    input  logic               load_n,
    input  logic               cnt_en,
    input  logic [TOTAL_W-1:0] data_in,
    output logic [TOTAL_W-1:0] q,
    output logic               carry_out
);

    // ent_chain[i] is the enable into slice i; ent_chain[i+1] is its carry.
    logic [NUM_SLICES:0] ent_chain;

    assign ent_chain[0] = cnt_en;

    for (genvar i = 0; i < NUM_SLICES; i++) begin : g_slice
        cnt_slice #(
            .WIDTH (SLICE_W)
        ) u_slice (
            .clk     (clk),
            .clear_n (clear_n),
            .load_n  (load_n),
            .en_p    (ent_chain[i]),
            .en_t    (ent_chain[i]),
            .d       (data_in[i*SLICE_W +: SLICE_W]),
            .q       (q[i*SLICE_W +: SLICE_W]),
            .rco     (ent_chain[i+1])
        );
    end

    assign carry_out = ent_chain[NUM_SLICES];

endmodule

// File: rtl/counter_chain_chk.sv
// Assertion checker for counter_chain, attached with bind.
// Assumes: checks start only after the first clear edge, so X values from
// before reset are never examined.
module counter_chain_chk #(
    parameter int TOTAL_W = 8,
    parameter int SLICE_W = 4
) (
    input logic               clk,
    input logic               clear_n,
    input logic               load_n,
    input logic               cnt_en,
    input logic [TOTAL_W-1:0] data_in,
    input logic [TOTAL_W-1:0] q,
    input logic               carry_out,
    input logic               lo_carry
);

    logic armed = 1'b0;

    // Arms the checks once the counter has seen a clear.
    always_ff @(posedge clk) begin
        if (!clear_n) armed <= 1'b1;
    end

    AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!armed)
        !clear_n |=> (q == '0)); // R1

    AST_LOAD_TAKES_DATA: assert property (@(posedge clk) disable iff (!armed)
        (clear_n && !load_n) |=> (q == $past(data_in))); // R2

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!armed)
        (clear_n && load_n && cnt_en) |=> (q == ($past(q) + {{(TOTAL_W-1){1'b0}}, 1'b1}))); // R3

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!armed)
        (clear_n && load_n && !cnt_en) |=> $stable(q)); // R4

    AST_LOW_CARRY: assert property (@(posedge clk) disable iff (!armed)
        lo_carry == (cnt_en && (q[SLICE_W-1:0] == {SLICE_W{1'b1}}))); // R5

    AST_TOP_CARRY: assert property (@(posedge clk) disable iff (!armed)
        carry_out == (cnt_en && (q == {TOTAL_W{1'b1}}))); // R6

    AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!armed)
        (clear_n && load_n && carry_out) |=> (q == '0)); // R7

endmodule

bind counter_chain counter_chain_chk #(
    .TOTAL_W (TOTAL_W),
    .SLICE_W (SLICE_W)
) u_chk (
    .clk       (clk),
    .clear_n   (clear_n),
    .load_n    (load_n),
    .cnt_en    (cnt_en),
    .data_in   (data_in),
    .q         (q),
    .carry_out (carry_out),
    .lo_carry  (ent_chain[1])
);

// File: tb/tb_counter_chain.sv
// Testbench for counter_chain. A behavioural model follows the requirements
// and is compared with the design after every clock edge.
module tb_counter_chain;

    logic       clk = 1'b0;
    logic       clear_n = 1'b0;
    logic       load_n = 1'b1;
    logic       cnt_en = 1'b0;
    logic [7:0] data_in = 8'h00;
    logic [7:0] q;
    logic       carry_out;

    int compared = 0;
    int mismatched = 0;
    int model_q = 0;
    int carry_rises = 0;
    logic prev_carry = 1'b0;

    always #4 clk = ~clk;  // 125 MHz

    counter_chain dut (
        .clk       (clk),
        .clear_n   (clear_n),
        .load_n    (load_n),
        .cnt_en    (cnt_en),
        .data_in   (data_in),
        .q         (q),
        .carry_out (carry_out)
    );

    task automatic report_summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    endtask

    // One cycle: drive inputs, let the edge pass, update the model, compare.
    task automatic step(input logic cn, input logic ln, input logic en,
                        input logic [7:0] d, input string tag);
        logic exp_carry;
        clear_n = cn;
        load_n  = ln;
        cnt_en  = en;
        data_in = d;
        @(posedge clk);
        if (!cn)       model_q = 0;
        else if (!ln)  model_q = int'(d);
        else if (en)   model_q = (model_q + 1) % 256;
        @(negedge clk);
        compared++;
        if (int'(q) != model_q) begin
            mismatched++;
            $display("FAIL %s: q actual %0d expected %0d", tag, q, model_q);
        end
        exp_carry = en && (model_q == 255);
        compared++;
        if (carry_out !== exp_carry) begin
            mismatched++;
            $display("FAIL R6: carry_out actual %0b expected %0b (q=%0d)",
                     carry_out, exp_carry, model_q);
        end
        if (carry_out && !prev_carry) carry_rises++;
        prev_carry = carry_out;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog: run did not end, actual hung expected done");
        report_summary();
        $finish;
    end

    initial begin
        // R1: reset state through clear
        step(1'b0, 1'b1, 1'b0, 8'h00, "R1");
        step(1'b0, 1'b1, 1'b0, 8'h00, "R1");
        // R3 and R5: count up from 0 across 0x0F into 0x10
        for (int i = 0; i < 20; i++) step(1'b1, 1'b1, 1'b1, 8'h77, (i == 15) ? "R5" : "R3");
        // R4: enable low holds
        for (int i = 0; i < 5; i++) step(1'b1, 1'b1, 1'b0, 8'h33, "R4");
        // R2: load while counting is enabled, then while disabled
        step(1'b1, 1'b0, 1'b1, 8'h0E, "R2");
        step(1'b1, 1'b0, 1'b0, 8'hA5, "R2");
        // R1: clear and load on the same edge, enable high
        step(1'b1, 1'b0, 1'b0, 8'h5A, "R2");
        step(1'b0, 1'b0, 1'b1, 8'hC3, "R1");
        // R8: count on from a loaded value, crossing a nibble boundary
        step(1'b1, 1'b0, 1'b0, 8'h3C, "R2");
        for (int i = 0; i < 6; i++) step(1'b1, 1'b1, 1'b1, 8'h00, "R8");
        // R6: at 255 with enable low the carry is off
        step(1'b1, 1'b0, 1'b0, 8'hFF, "R2");
        for (int i = 0; i < 3; i++) step(1'b1, 1'b1, 1'b0, 8'h00, "R6");
        // R7: wrap from 255 to 0
        step(1'b1, 1'b0, 1'b0, 8'hFD, "R2");
        for (int i = 0; i < 5; i++) step(1'b1, 1'b1, 1'b1, 8'h00, "R7");
        // R7: free run from 0 through two full periods
        step(1'b0, 1'b1, 1'b1, 8'h00, "R1");
        carry_rises = 0;
        prev_carry  = 1'b0;
        for (int i = 0; i < 512; i++) step(1'b1, 1'b1, 1'b1, 8'h00, "R7");
        compared++;
        if (carry_rises != 2) begin
            mismatched++;
            $display("FAIL R7: carry rises actual %0d expected 2", carry_rises);
        end
        report_summary();
        $finish;
    end

endmodule